// File: doc/BRIEF.md
# SDRAM Command Tracker

This block watches the control pins of a single-data-rate SDRAM from the device side. On every rising clock edge it turns the chip-select, row strobe, column strobe, write strobe and clock-enable levels into one command. It keeps a model of every bank: whether it is idle or has a row open, which row is open, and how many clocks remain before a closed bank may be opened again. Commands that break the access rules are flagged on a one-cycle error output and have no effect on that model.

It also follows the current data burst. The burst length comes from the mode-register op-code. Auto-precharge can be requested on each access, and the burst can be cut short by a later command. From this state the block drives per-byte-lane write enables in the same cycle as the write data. It also drives per-lane read output enables, which follow the lane mask two clocks late. A memory model or a protocol monitor sits behind these outputs.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select low, strobes {row, col, write} decode as 111 NOP (code 1), 011 ACTIVE (2), 101 READ (3), 100 WRITE (4), 110 BURST STOP (5), 010 PRECHARGE (6), 001 AUTO REFRESH (7), 000 MODE LOAD (9). Chip select high is INHIBIT (0). `cmd_o` shows the code one clock after the edge that samples it.
- R2: With clock enable low, the refresh encoding is SELF REFRESH (code 8). Any encoding other than NOP, INHIBIT or refresh is flagged as an error and has no effect.
- R3: A legal ACTIVE opens the bank selected by `bank_sel` and records the row from all 13 address bits. ACTIVE to a bank that is open or still inside its precharge wait is an error.
- R4: READ or WRITE to a bank that is not open is an error. It is also an error to a bank whose auto-precharge burst is still running. A legal access places the column {A11, A9..A0} on `col_o`.
- R5: PRECHARGE with A10 high closes every bank. With A10 low it closes only the selected bank. A bank closed at edge k reports `bank_ready_o` after edge k+TRP-1, and an ACTIVE to it is accepted at edge k+TRP or later.
- R6: A10 high on a READ or WRITE applies to that command only. The bank closes at the edge of the last data beat, as a PRECHARGE issued there would.
- R7: Mode code 7 selects full-page bursts. These run until a BURST STOP, a new READ or WRITE, or a PRECHARGE of their bank, and auto-precharge is ignored for them.
- R8: `wr_byte_en_o` equals the inverted lane mask in every write beat cycle and is zero in all other cycles. This includes illegal writes and the cycle of a BURST STOP.
- R9: `rd_oe_o` equals the inverted lane mask sampled two edges earlier.
- R10: MODE LOAD, AUTO REFRESH and SELF REFRESH are errors unless every bank is ready. MODE LOAD is also an error when A12 is high. Op-code bits 2:0 pick the burst length: 0→1, 1→2, 2→4, 3→8, 7→full page, others→1.
- R11: `cmd_err_o` is high for exactly the cycle after an illegal command and low after a legal one.
- R12: After reset, `cmd_o` is 0, no error is shown, every bank is idle and ready, read enables are zero, and the burst length is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| clk_en | input | 1 | Clock enable |
| bank_sel | input | 2 | Bank select |
| addr | input | 13 | Address / op-code |
| lane_mask | input | 8 | Per-byte data mask, high masks |
| cmd_o | output | 4 | Decoded command of the previous edge |
| cmd_err_o | output | 1 | Illegal-command flag |
| bank_open_o | output | 4 | Bank has an open row |
| bank_ready_o | output | 4 | Bank idle and past its precharge wait |
| open_row_o | output | 52 | Open row per bank, bank b at bits 13b+12..13b |
| col_o | output | 11 | Column of the last legal access |
| wr_byte_en_o | output | 8 | Write enable per byte lane |
| rd_oe_o | output | 8 | Read output enable per byte lane |

## Verification
The outputs fall into three timing groups. `cmd_o`, `cmd_err_o`, bank state, row and column are registered, so they are sampled at the falling edge after the rising edge that takes the command. `wr_byte_en_o` has no register in its path and is sampled 1 ns after the inputs change, before the next rising edge. `rd_oe_o` is compared two falling edges after its mask is applied, and also one falling edge after, to show it has not yet moved. The precharge wait and the auto-precharge close are checked edge by edge around the cycle where each is due.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_ACT     = 4'd2,
        CMD_RD      = 4'd3,
        CMD_WR      = 4'd4,
        CMD_STOP    = 4'd5,
        CMD_PRE     = 4'd6,
        CMD_AREF    = 4'd7,
        CMD_SREF    = 4'd8,
        CMD_MODE    = 4'd9
    } cmd_e;

    localparam logic [2:0] BLC_FULL = 3'd7;

    // beats remaining after the first one, per burst-length code
    function automatic logic [2:0] beats_after_first(input logic [2:0] code);
        case (code)
            3'd1:    beats_after_first = 3'd1;
            3'd2:    beats_after_first = 3'd3;
            3'd3:    beats_after_first = 3'd7;
            default: beats_after_first = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic chip_sel_n,
    input  logic row_strobe_n,
    input  logic col_strobe_n,
    input  logic wr_strobe_n,
    input  logic clk_en,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (chip_sel_n) begin
            cmd = CMD_INHIBIT;
        end else begin
            case ({row_strobe_n, col_strobe_n, wr_strobe_n})
                3'b111: cmd = CMD_NOP;
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b110: cmd = CMD_STOP;
                3'b010: cmd = CMD_PRE;
                3'b001: cmd = clk_en ? CMD_AREF : CMD_SREF;
                default: cmd = CMD_MODE;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
    parameter int ROW_W = 13,
    parameter int TRP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic             ready,
    output logic [ROW_W-1:0] row_out
);

    localparam int CNT_W = $clog2(TRP + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] wait_cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - 1'b1;
        end
        if (open_req) begin
            st_d.open = 1'b1;
            st_d.row  = row_in;
        end
        if (close_req && st_q.open) begin
            st_d.open     = 1'b0;
            st_d.wait_cnt = CNT_W'(TRP - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign is_open = st_q.open;
    assign ready   = !st_q.open && (st_q.wait_cnt == '0);
    assign row_out = st_q.row;

    // the controller may only open a bank that reports ready
    p_open_when_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        open_req |-> ready)
        else $error("bank opened while not ready");

    // an open bank never carries a pending precharge wait
    p_open_no_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.open |-> (st_q.wait_cnt == '0))
        else $error("open bank still in precharge wait");

endmodule

// File: rtl/sdcmd_lanes.sv
module sdcmd_lanes #(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_mask,
    input  logic             wr_beat,
    output logic [LANES-1:0] wr_byte_en,
    output logic [LANES-1:0] rd_oe
);

    typedef struct packed {
        logic [LANES-1:0] stage1;
        logic [LANES-1:0] stage2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.stage1 = lane_mask;
        pipe_d.stage2 = pipe_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rd_oe      = ~pipe_q.stage2;
    assign wr_byte_en = wr_beat ? ~lane_mask : '0;

    // history depth seen since reset, for the delayed-mask check
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_read_mask_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (rd_oe == ~$past(lane_mask, 2)))
        else $error("read enable not two clocks behind mask");

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ADDR_W = 13,
    parameter int LANES  = 8,
    parameter int TRP    = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chip_sel_n,
    input  logic                    row_strobe_n,
    input  logic                    col_strobe_n,
    input  logic                    wr_strobe_n,
    input  logic                    clk_en,
    input  logic [1:0]              bank_sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_mask,
    output logic [3:0]              cmd_o,
    output logic                    cmd_err_o,
    output logic [BANKS-1:0]        bank_open_o,
    output logic [BANKS-1:0]        bank_ready_o,
    output logic [BANKS*ADDR_W-1:0] open_row_o,
    output logic [10:0]             col_o,
    output logic [LANES-1:0]        wr_byte_en_o,
    output logic [LANES-1:0]        rd_oe_o
);

    localparam int BA_W   = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W;
    localparam int COL_W  = 11;
    localparam int AP_BIT = 10;

    typedef struct packed {
        cmd_e             cmd;
        logic             err;
        logic [2:0]       bl_code;
        logic [COL_W-1:0] col;
        logic             live;
        logic             wr;
        logic             full;
        logic             ap;
        logic [BA_W-1:0]  bank;
        logic [2:0]       rem;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    cmd_e             cmd_now;
    logic [BA_W-1:0]  bsel;
    logic             ap_bit;
    logic             all_ready;
    logic             illegal;
    logic             legal;
    logic             truncate;
    logic             ap_close_old;
    logic             ap_close_new;
    logic             wr_beat;
    logic [BANKS-1:0] open_req;
    logic [BANKS-1:0] close_req;

    assign bsel      = bank_sel[BA_W-1:0];
    assign ap_bit    = addr[AP_BIT];
    assign all_ready = &bank_ready_o;

    sdcmd_decode u_decode (
        .chip_sel_n   (chip_sel_n),
        .row_strobe_n (row_strobe_n),
        .col_strobe_n (col_strobe_n),
        .wr_strobe_n  (wr_strobe_n),
        .clk_en       (clk_en),
        .cmd          (cmd_now)
    );

    // legality of the command sampled at this edge
    always_comb begin
        illegal = 1'b0;
        case (cmd_now)
            CMD_ACT:          illegal = !bank_ready_o[bsel];
            CMD_RD, CMD_WR:   illegal = !bank_open_o[bsel] ||
                                        (ctrl_q.live && ctrl_q.ap && ctrl_q.bank == bsel);
            CMD_AREF,
            CMD_SREF:         illegal = !all_ready;
            CMD_MODE:         illegal = !all_ready || addr[ADDR_W-1];
            default:          illegal = 1'b0;
        endcase
        if (!clk_en && !(cmd_now inside {CMD_INHIBIT, CMD_NOP, CMD_SREF})) begin
            illegal = 1'b1;
        end
        legal = !illegal;
    end

    // burst tracking and bank requests
    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.cmd   = cmd_now;
        ctrl_d.err   = illegal;
        ap_close_new = 1'b0;

        truncate = ctrl_q.live && legal &&
                   ((cmd_now inside {CMD_RD, CMD_WR, CMD_STOP}) ||
                    (cmd_now == CMD_PRE && (ap_bit || bsel == ctrl_q.bank)));
        ap_close_old = ctrl_q.live && ctrl_q.ap && (truncate || ctrl_q.rem == 3'd1);

        if (legal && (cmd_now inside {CMD_RD, CMD_WR})) begin
            ctrl_d.col  = {addr[11], addr[9:0]};
            ctrl_d.full = (ctrl_q.bl_code == BLC_FULL);
            ctrl_d.rem  = beats_after_first(ctrl_q.bl_code);
            ctrl_d.live = ctrl_d.full || (ctrl_d.rem != 3'd0);
            ctrl_d.ap   = ap_bit && !ctrl_d.full && (ctrl_d.rem != 3'd0);
            ctrl_d.wr   = (cmd_now == CMD_WR);
            ctrl_d.bank = bsel;
            ap_close_new = ap_bit && !ctrl_d.full && (ctrl_d.rem == 3'd0);
        end else if (truncate) begin
            ctrl_d.live = 1'b0;
            ctrl_d.ap   = 1'b0;
            ctrl_d.rem  = 3'd0;
        end else if (ctrl_q.live && !ctrl_q.full) begin
            ctrl_d.rem = ctrl_q.rem - 3'd1;
            if (ctrl_q.rem == 3'd1) begin
                ctrl_d.live = 1'b0;
                ctrl_d.ap   = 1'b0;
            end
        end

        if (legal && cmd_now == CMD_MODE) begin
            ctrl_d.bl_code = addr[2:0];
        end

        wr_beat = (legal && cmd_now == CMD_WR) || (ctrl_q.live && ctrl_q.wr && !truncate);

        for (int b = 0; b < BANKS; b++) begin
            open_req[b]  = legal && cmd_now == CMD_ACT && bsel == BA_W'(b);
            close_req[b] = (legal && cmd_now == CMD_PRE && (ap_bit || bsel == BA_W'(b))) ||
                           (ap_close_old && ctrl_q.bank == BA_W'(b)) ||
                           (ap_close_new && bsel == BA_W'(b));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            ctrl_q.cmd <= CMD_INHIBIT;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
        sdcmd_bank #(
            .ROW_W (ROW_W),
            .TRP   (TRP)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[gb]),
            .close_req (close_req[gb]),
            .row_in    (addr[ROW_W-1:0]),
            .is_open   (bank_open_o[gb]),
            .ready     (bank_ready_o[gb]),
            .row_out   (open_row_o[gb*ROW_W +: ROW_W])
        );
    end

    sdcmd_lanes #(
        .LANES (LANES)
    ) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_mask  (lane_mask),
        .wr_beat    (wr_beat),
        .wr_byte_en (wr_byte_en_o),
        .rd_oe      (rd_oe_o)
    );

    assign cmd_o     = ctrl_q.cmd;
    assign cmd_err_o = ctrl_q.err;
    assign col_o     = ctrl_q.col;

    p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cmd == CMD_ACT && !ctrl_q.err) |-> (bank_open_o != '0))
        else $error("accepted ACTIVE left no bank open");

    p_mode_all_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cmd == CMD_MODE && !ctrl_q.err) |-> (bank_open_o == '0))
        else $error("mode load accepted with a bank open");

    p_write_lane_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_en_o != '0) |-> ((ctrl_q.live && ctrl_q.wr) || cmd_now == CMD_WR))
        else $error("write lane enabled outside a write beat");

    p_err_blocks_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_ACT && illegal) |=> $stable(bank_open_o))
        else $error("rejected ACTIVE changed bank state");

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_sel_n, row_strobe_n, col_strobe_n, wr_strobe_n, clk_en;
    logic [1:0]  bank_sel;
    logic [12:0] addr;
    logic [7:0]  lane_mask;
    logic [3:0]  cmd_o;
    logic        cmd_err_o;
    logic [3:0]  bank_open_o, bank_ready_o;
    logic [51:0] open_row_o;
    logic [10:0] col_o;
    logic [7:0]  wr_byte_en_o, rd_oe_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .row_strobe_n(row_strobe_n),
        .col_strobe_n(col_strobe_n), .wr_strobe_n(wr_strobe_n), .clk_en(clk_en),
        .bank_sel(bank_sel), .addr(addr), .lane_mask(lane_mask), .cmd_o(cmd_o),
        .cmd_err_o(cmd_err_o), .bank_open_o(bank_open_o), .bank_ready_o(bank_ready_o),
        .open_row_o(open_row_o), .col_o(col_o), .wr_byte_en_o(wr_byte_en_o),
        .rd_oe_o(rd_oe_o)
    );

    // strobes as {chip select, row, column, write}
    localparam logic [3:0] S_INH = 4'b1000, S_NOP = 4'b0111, S_ACT = 4'b0011,
                           S_RD  = 4'b0101, S_WR  = 4'b0100, S_STP = 4'b0110,
                           S_PRE = 4'b0010, S_REF = 4'b0001, S_MOD = 4'b0000;

    typedef struct packed {
        logic [3:0]  strb;
        logic        cke;
        logic [1:0]  ba;
        logic [12:0] ad;
        logic [7:0]  msk;
        logic [3:0]  e_cmd;
        logic        e_err;
        logic [3:0]  e_open;
        logic [7:0]  e_wbe;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{S_NOP, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd1, 1'b0, 4'h0, 8'h00}, // R1 nop
        '{S_INH, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd0, 1'b0, 4'h0, 8'h00}, // R1 inhibit
        '{S_WR,  1'b1, 2'd0, 13'h0000, 8'h00, 4'd4, 1'b1, 4'h0, 8'h00}, // R4 R8 write to idle
        '{S_MOD, 1'b1, 2'd0, 13'h0001, 8'h00, 4'd9, 1'b0, 4'h0, 8'h00}, // R10 burst 2
        '{S_ACT, 1'b1, 2'd0, 13'h0ABC, 8'h00, 4'd2, 1'b0, 4'h1, 8'h00}, // R3 open bank0
        '{S_ACT, 1'b1, 2'd0, 13'h0123, 8'h00, 4'd2, 1'b1, 4'h1, 8'h00}, // R3 R11 reopen
        '{S_MOD, 1'b1, 2'd0, 13'h0003, 8'h00, 4'd9, 1'b1, 4'h1, 8'h00}, // R10 mode while open
        '{S_WR,  1'b1, 2'd0, 13'h0005, 8'h0F, 4'd4, 1'b0, 4'h1, 8'hF0}, // R8 beat 1
        '{S_NOP, 1'b1, 2'd0, 13'h0000, 8'hAA, 4'd1, 1'b0, 4'h1, 8'h55}, // R8 beat 2
        '{S_NOP, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd1, 1'b0, 4'h1, 8'h00}, // R8 burst over
        '{S_REF, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd7, 1'b1, 4'h1, 8'h00}, // R10 refresh while open
        '{S_ACT, 1'b1, 2'd2, 13'h0005, 8'h00, 4'd2, 1'b0, 4'h5, 8'h00}, // R3 open bank2
        '{S_PRE, 1'b1, 2'd1, 13'h0400, 8'h00, 4'd6, 1'b0, 4'h0, 8'h00}, // R5 close all
        '{S_ACT, 1'b1, 2'd2, 13'h0007, 8'h00, 4'd2, 1'b1, 4'h0, 8'h00}, // R5 inside wait
        '{S_NOP, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd1, 1'b0, 4'h0, 8'h00},
        '{S_ACT, 1'b1, 2'd2, 13'h0007, 8'h00, 4'd2, 1'b0, 4'h4, 8'h00}, // R5 wait over
        '{S_RD,  1'b1, 2'd2, 13'h0400, 8'h00, 4'd3, 1'b0, 4'h4, 8'h00}, // R6 read, autoclose
        '{S_NOP, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd1, 1'b0, 4'h0, 8'h00}, // R6 closed at last beat
        '{S_ACT, 1'b1, 2'd2, 13'h0007, 8'h00, 4'd2, 1'b1, 4'h0, 8'h00}, // R6 wait after autoclose
        '{S_ACT, 1'b0, 2'd1, 13'h0007, 8'h00, 4'd2, 1'b1, 4'h0, 8'h00}, // R2 active with cke low
        '{S_REF, 1'b0, 2'd0, 13'h0000, 8'h00, 4'd8, 1'b0, 4'h0, 8'h00}, // R2 self refresh
        '{S_MOD, 1'b1, 2'd0, 13'h1007, 8'h00, 4'd9, 1'b1, 4'h0, 8'h00}, // R10 A12 high
        '{S_MOD, 1'b1, 2'd0, 13'h0007, 8'h00, 4'd9, 1'b0, 4'h0, 8'h00}, // R10 full page
        '{S_ACT, 1'b1, 2'd3, 13'h1FFF, 8'h00, 4'd2, 1'b0, 4'h8, 8'h00}, // R3 open bank3
        '{S_WR,  1'b1, 2'd3, 13'h0400, 8'h00, 4'd4, 1'b0, 4'h8, 8'hFF}, // R7 full page write
        '{S_NOP, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd1, 1'b0, 4'h8, 8'hFF}, // R7 continues
        '{S_NOP, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd1, 1'b0, 4'h8, 8'hFF}, // R7 autoclose ignored
        '{S_STP, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd5, 1'b0, 4'h8, 8'h00}, // R7 stop
        '{S_NOP, 1'b1, 2'd0, 13'h0000, 8'h00, 4'd1, 1'b0, 4'h8, 8'h00}, // R7 no more beats
        '{S_PRE, 1'b1, 2'd3, 13'h0000, 8'h00, 4'd6, 1'b0, 4'h0, 8'h00}  // R5 single bank
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] s, input logic cke, input logic [1:0] ba,
                         input logic [12:0] ad, input logic [7:0] m);
        {chip_sel_n, row_strobe_n, col_strobe_n, wr_strobe_n} = s;
        clk_en = cke; bank_sel = ba; addr = ad; lane_mask = m;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        drive(S_NOP, 1'b1, 2'd0, 13'h0, 8'hFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 cmd", 64'(cmd_o), 64'd0);
        chk("R12 err", 64'(cmd_err_o), 64'd0);
        chk("R12 open", 64'(bank_open_o), 64'h0);
        chk("R12 ready", 64'(bank_ready_o), 64'hF);
        chk("R12 rd_oe", 64'(rd_oe_o), 64'h0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].strb, TBL[i].cke, TBL[i].ba, TBL[i].ad, TBL[i].msk);
            #1;
            chk("R8 write lanes", 64'(wr_byte_en_o), 64'(TBL[i].e_wbe));
            @(negedge clk);
            chk("R1 command", 64'(cmd_o), 64'(TBL[i].e_cmd));
            chk("R11 error", 64'(cmd_err_o), 64'(TBL[i].e_err));
            chk("R3 R5 R6 bank open", 64'(bank_open_o), 64'(TBL[i].e_open));
        end

        // let the bank3 wait expire, then select burst length 4 (R10)
        drive(S_NOP, 1'b1, 2'd0, 13'h0, 8'h00);
        repeat (4) @(negedge clk);
        drive(S_MOD, 1'b1, 2'd0, 13'h0002, 8'h00);
        @(negedge clk);
        chk("R10 mode accepted", 64'(cmd_err_o), 64'd0);

        drive(S_ACT, 1'b1, 2'd1, 13'h1555, 8'h00);
        @(negedge clk);
        chk("R3 row capture", 64'(open_row_o[13 +: 13]), 64'h1555);

        drive(S_RD, 1'b1, 2'd1, 13'h0D55, 8'h00);   // A11=1, A10=1, column low bits 0x155
        @(negedge clk);
        chk("R4 column", 64'(col_o), 64'h555);
        drive(S_RD, 1'b1, 2'd1, 13'h0000, 8'h00);
        @(negedge clk);
        chk("R4 access during autoclose burst", 64'(cmd_err_o), 64'd1);
        drive(S_NOP, 1'b1, 2'd0, 13'h0, 8'h00);
        @(negedge clk);
        chk("R6 open before last beat", 64'(bank_open_o[1]), 64'd1);
        @(negedge clk);
        chk("R6 closed at last beat", 64'(bank_open_o[1]), 64'd0);
        chk("R5 not ready at close", 64'(bank_ready_o[1]), 64'd0);
        @(negedge clk);
        chk("R5 not ready one later", 64'(bank_ready_o[1]), 64'd0);
        @(negedge clk);
        chk("R5 ready after wait", 64'(bank_ready_o[1]), 64'd1);

        // R9 read enable two clocks behind mask
        drive(S_NOP, 1'b1, 2'd0, 13'h0, 8'hFF);
        repeat (2) @(negedge clk);
        lane_mask = 8'h5A;
        @(negedge clk);
        chk("R9 rd_oe after one edge", 64'(rd_oe_o), 64'h00);
        @(negedge clk);
        chk("R9 rd_oe after two edges", 64'(rd_oe_o), 64'hA5);

        finish_run();
    end

endmodule